// File: doc/BRIEF.md
# Switch-on-Miss Thread Squash Controller

This block steers thread flushes in a multithreaded in-order pipeline that hands the pipeline to another thread whenever a data access misses. Each stage reports a level memory-stall flag, together with the thread, sequence number and instruction word of the access that is waiting. In switch-on-miss mode the controller picks one stalled instruction and copies it into a per-thread holding register. It then broadcasts a one-cycle squash to the stalling stage and to every stage in front of it. The squash threshold is one below the stalling sequence number, so the stage buffers also drop the stalling instruction and free their slots. The memory access unit gets a separate squash whose keep-point is the stalling sequence number itself, so the outstanding miss is not cancelled.

Stages may also ask for a branch squash. These requests are held by the stage until acknowledged. The controller takes at most one squash per cycle. A branch request for a thread that is already being squashed at an older point in the same cycle is acknowledged without a squash of its own. Any other losing request stays pending and is taken in a later cycle. When the miss completes, a restore request releases the parked instruction for one cycle so the first stage can reinject it.

The control state machine has two states. The `IDLE` state watches for stalls. Its transition *detect* parks the stalling instruction and either issues the squash at once (zero delay) or loads the delay counter and moves to `DELAY`. In `DELAY`, the transition *count* decrements the counter. The transition *fire* issues the parked event's squash and returns to `IDLE`.

Top module: `miss_switch_squash`

## Requirements
- R1: With `switch_on_miss` high, a stall flag at stage s whose thread has no parked instruction causes, in the cycle after the detecting edge (zero delay), `stage_squash` bits 0 through s to be set (bit k is stage k, stage 0 is the first), `squash_tid` to equal the thread and `squash_thresh` to equal the stalling sequence number minus one, modulo 2^16. Stage s uses the fields `stall_tid[s*2 +: 2]`, `stall_seq[s*16 +: 16]` and `stall_inst[s*32 +: 32]`.
- R2: While `switch_on_miss` is low, stall flags cause no squash and park nothing.
- R3: At the detecting edge the stalling instruction is stored for its thread, and bit t of `parked_valid` is set for thread t.
- R4: A stall squash also pulses `mem_squash`, with `mem_keep_seq` equal to the stalling sequence number (`squash_thresh` + 1).
- R5: Squash, acknowledge and reinject outputs are registered pulses that clear in the following cycle when no new event arrives.
- R6: When several stages flag stalls in one cycle, the deepest (highest-numbered) stage is served first. The others are served in later cycles while their flags stay up and their threads are not parked.
- R7: A stall from a thread whose `parked_valid` bit is set causes no squash and does not overwrite the stored instruction.
- R8: `restore_req` for a parked thread clears its `parked_valid` bit and, one cycle later, pulses `reinject_vld` with the stored tid, sequence number and instruction word. A restore for a thread with nothing parked produces no reinject.
- R9: A branch request from stage b (fields `br_tid[b*2 +: 2]`, `br_seq[b*16 +: 16]`) that is taken squashes stages 0 through b with `squash_thresh` equal to the branch sequence number. It leaves `mem_squash` low and pulses `br_done[b]`.
- R10: A branch request whose thread matches the squash taken in the same cycle, and whose sequence number is greater than that squash's threshold, is acknowledged through `br_done` without producing a squash of its own.
- R11: A stall squash has priority over branch requests, and among branch requests the deepest stage wins. Other requests get no `br_done` and are taken in a later cycle.
- R12: With parameter `SQ_DELAY` = D, the instruction is parked at the detecting edge, but the squash outputs appear D cycles later than with zero delay.
- R13: During and right after reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| switch_on_miss | input | 1 | Switch-on-miss thread mode enable |
| stall_flag | input | NUM_STAGES | Per-stage memory-stall flag (level) |
| stall_tid | input | NUM_STAGES*TID_W | Per-stage thread of the stalled access |
| stall_seq | input | NUM_STAGES*SEQ_W | Per-stage sequence number of the stalled access |
| stall_inst | input | NUM_STAGES*INST_W | Per-stage instruction word of the stalled access |
| br_req | input | NUM_STAGES | Per-stage branch squash request, held until acknowledged |
| br_tid | input | NUM_STAGES*TID_W | Branch request thread |
| br_seq | input | NUM_STAGES*SEQ_W | Branch request sequence number |
| restore_req | input | 1 | Miss completed, release parked instruction |
| restore_tid | input | TID_W | Thread to restore |
| stage_squash | output | NUM_STAGES | Per-stage squash pulse |
| squash_tid | output | TID_W | Thread being squashed |
| squash_thresh | output | SEQ_W | Keep entries at or below this sequence number |
| mem_squash | output | 1 | Squash pulse to the memory access unit |
| mem_keep_seq | output | SEQ_W | Memory unit keep-point (stalling sequence number) |
| br_done | output | NUM_STAGES | Branch request acknowledge pulse |
| parked_valid | output | 2**TID_W | Per-thread parked-instruction valid |
| reinject_vld | output | 1 | Parked instruction presented for reinjection |
| reinject_tid | output | TID_W | Thread of the reinjected instruction |
| reinject_seq | output | SEQ_W | Sequence number of the reinjected instruction |
| reinject_inst | output | INST_W | Instruction word of the reinjected instruction |

## Verification
The bench builds two copies of the block on the same stimulus. One uses the defaults (five stages, 16-bit sequence numbers, four threads, zero delay) and carries every directed scenario: stage arbitration, branch filtering, hold-off of parked threads, restore, and the wrap of sequence number zero to a threshold of all ones. The second copy sets `SQ_DELAY` to 3. This exercises the counting state and shows that parking happens at detection while the squash moves by exactly three cycles.

// File: rtl/mss_pkg.sv
package mss_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_DELAY = 1'b1
    } mss_state_e;

endpackage

// File: rtl/mss_stall_pick.sv
module mss_stall_pick #(
    parameter int NUM_STAGES  = 5,
    parameter int TID_W       = 2,
    parameter int NUM_THREADS = 4,
    parameter int STG_W       = 3
) (
    input  logic                        enable,
    input  logic [NUM_STAGES-1:0]       flag,
    input  logic [NUM_STAGES*TID_W-1:0] tid_flat,
    input  logic [NUM_THREADS-1:0]      parked,
    output logic                        found,
    output logic [STG_W-1:0]            stage
);

    logic [NUM_STAGES-1:0] eligible;

    // a stage qualifies only if its thread has no instruction parked
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_elig
        assign eligible[s] = enable && flag[s] && !parked[tid_flat[s*TID_W +: TID_W]];
    end

    // later (deeper) stages override earlier ones
    always_comb begin
        found = 1'b0;
        stage = '0;
        for (int s = 0; s < NUM_STAGES; s++) begin
            if (eligible[s]) begin
                found = 1'b1;
                stage = STG_W'(s);
            end
        end
    end

endmodule

// File: rtl/mss_park_bank.sv
module mss_park_bank #(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2,
    parameter int SEQ_W       = 16,
    parameter int INST_W      = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cap_en,
    input  logic [TID_W-1:0]       cap_tid,
    input  logic [SEQ_W-1:0]       cap_seq,
    input  logic [INST_W-1:0]      cap_inst,
    input  logic                   rel_en,
    input  logic [TID_W-1:0]       rel_tid,
    output logic [NUM_THREADS-1:0] parked,
    output logic                   out_vld,
    output logic [TID_W-1:0]       out_tid,
    output logic [SEQ_W-1:0]       out_seq,
    output logic [INST_W-1:0]      out_inst
);

    logic [SEQ_W-1:0]  seq_q  [NUM_THREADS];
    logic [INST_W-1:0] inst_q [NUM_THREADS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            parked <= '0;
            for (int t = 0; t < NUM_THREADS; t++) begin
                seq_q[t]  <= '0;
                inst_q[t] <= '0;
            end
        end else begin
            for (int t = 0; t < NUM_THREADS; t++) begin
                if (cap_en && cap_tid == TID_W'(t)) begin
                    parked[t] <= 1'b1;
                    seq_q[t]  <= cap_seq;
                    inst_q[t] <= cap_inst;
                end else if (rel_en && rel_tid == TID_W'(t)) begin
                    parked[t] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_tid  <= '0;
            out_seq  <= '0;
            out_inst <= '0;
        end else begin
            out_vld  <= rel_en && parked[rel_tid];
            out_tid  <= rel_tid;
            out_seq  <= seq_q[rel_tid];
            out_inst <= inst_q[rel_tid];
        end
    end

endmodule

// File: rtl/mss_branch_filter.sv
module mss_branch_filter #(
    parameter int NUM_STAGES = 5,
    parameter int TID_W      = 2,
    parameter int SEQ_W      = 16,
    parameter int STG_W      = 3
) (
    input  logic [NUM_STAGES-1:0]       req,
    input  logic [NUM_STAGES*TID_W-1:0] tid_flat,
    input  logic [NUM_STAGES*SEQ_W-1:0] seq_flat,
    input  logic                        stall_take,
    input  logic [TID_W-1:0]            stall_tid,
    input  logic [SEQ_W-1:0]            stall_thr,
    output logic                        br_take,
    output logic [STG_W-1:0]            br_stage,
    output logic [TID_W-1:0]            take_tid,
    output logic [SEQ_W-1:0]            take_thr,
    output logic [NUM_STAGES-1:0]       done
);

    logic br_found;
    logic any_take;

    always_comb begin
        br_found = 1'b0;
        br_stage = '0;
        for (int s = 0; s < NUM_STAGES; s++) begin
            if (req[s]) begin
                br_found = 1'b1;
                br_stage = STG_W'(s);
            end
        end
        br_take  = br_found && !stall_take;
        any_take = br_found || stall_take;
        take_tid = stall_take ? stall_tid : tid_flat[br_stage*TID_W +: TID_W];
        take_thr = stall_take ? stall_thr : seq_flat[br_stage*SEQ_W +: SEQ_W];
        for (int s = 0; s < NUM_STAGES; s++) begin
            done[s] = req[s] &&
                      ((br_take && br_stage == STG_W'(s)) ||
                       (any_take && tid_flat[s*TID_W +: TID_W] == take_tid &&
                        seq_flat[s*SEQ_W +: SEQ_W] > take_thr));
        end
    end

endmodule

// File: rtl/miss_switch_squash.sv
module miss_switch_squash
    import mss_pkg::*;
#(
    parameter int NUM_STAGES = 5,
    parameter int SEQ_W      = 16,
    parameter int TID_W      = 2,
    parameter int INST_W     = 32,
    parameter int SQ_DELAY   = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          switch_on_miss,
    input  logic [NUM_STAGES-1:0]         stall_flag,
    input  logic [NUM_STAGES*TID_W-1:0]   stall_tid,
    input  logic [NUM_STAGES*SEQ_W-1:0]   stall_seq,
    input  logic [NUM_STAGES*INST_W-1:0]  stall_inst,
    input  logic [NUM_STAGES-1:0]         br_req,
    input  logic [NUM_STAGES*TID_W-1:0]   br_tid,
    input  logic [NUM_STAGES*SEQ_W-1:0]   br_seq,
    input  logic                          restore_req,
    input  logic [TID_W-1:0]              restore_tid,
    output logic [NUM_STAGES-1:0]         stage_squash,
    output logic [TID_W-1:0]              squash_tid,
    output logic [SEQ_W-1:0]              squash_thresh,
    output logic                          mem_squash,
    output logic [SEQ_W-1:0]              mem_keep_seq,
    output logic [NUM_STAGES-1:0]         br_done,
    output logic [(2**TID_W)-1:0]         parked_valid,
    output logic                          reinject_vld,
    output logic [TID_W-1:0]              reinject_tid,
    output logic [SEQ_W-1:0]              reinject_seq,
    output logic [INST_W-1:0]             reinject_inst
);

    localparam int NUM_THREADS = 2**TID_W;
    localparam int STG_W       = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1;
    localparam int CNT_W       = (SQ_DELAY > 0) ? $clog2(SQ_DELAY + 1) : 1;

    mss_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [STG_W-1:0]  ev_stage_q;
    logic [TID_W-1:0]  ev_tid_q;
    logic [SEQ_W-1:0]  ev_seq_q;

    logic              pick_found;
    logic [STG_W-1:0]  pick_stage;
    logic [TID_W-1:0]  pick_tid;
    logic [SEQ_W-1:0]  pick_seq;
    logic [INST_W-1:0] pick_inst;

    logic              st_take;
    logic [STG_W-1:0]  st_stage;
    logic [TID_W-1:0]  st_tid;
    logic [SEQ_W-1:0]  st_seq;
    logic [SEQ_W-1:0]  st_thr;

    logic [NUM_STAGES-1:0] br_live;
    logic                  br_take;
    logic [STG_W-1:0]      br_stage;
    logic [TID_W-1:0]      take_tid;
    logic [SEQ_W-1:0]      take_thr;
    logic [NUM_STAGES-1:0] done_d;
    logic [NUM_STAGES-1:0] mask_d;

    mss_stall_pick #(
        .NUM_STAGES (NUM_STAGES),
        .TID_W      (TID_W),
        .NUM_THREADS(NUM_THREADS),
        .STG_W      (STG_W)
    ) u_pick (
        .enable  (switch_on_miss && state_q == ST_IDLE),
        .flag    (stall_flag),
        .tid_flat(stall_tid),
        .parked  (parked_valid),
        .found   (pick_found),
        .stage   (pick_stage)
    );

    assign pick_tid  = stall_tid[pick_stage*TID_W +: TID_W];
    assign pick_seq  = stall_seq[pick_stage*SEQ_W +: SEQ_W];
    assign pick_inst = stall_inst[pick_stage*INST_W +: INST_W];

    mss_park_bank #(
        .NUM_THREADS(NUM_THREADS),
        .TID_W      (TID_W),
        .SEQ_W      (SEQ_W),
        .INST_W     (INST_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (pick_found),
        .cap_tid (pick_tid),
        .cap_seq (pick_seq),
        .cap_inst(pick_inst),
        .rel_en  (restore_req),
        .rel_tid (restore_tid),
        .parked  (parked_valid),
        .out_vld (reinject_vld),
        .out_tid (reinject_tid),
        .out_seq (reinject_seq),
        .out_inst(reinject_inst)
    );

    // stall event issue: immediate with zero delay, else from the parked event
    always_comb begin
        st_take  = 1'b0;
        st_stage = pick_stage;
        st_tid   = pick_tid;
        st_seq   = pick_seq;
        if (SQ_DELAY == 0) begin
            st_take = pick_found;
        end else if (state_q == ST_DELAY && cnt_q == CNT_W'(1)) begin
            st_take  = 1'b1;
            st_stage = ev_stage_q;
            st_tid   = ev_tid_q;
            st_seq   = ev_seq_q;
        end
        st_thr = st_seq - SEQ_W'(1);
    end

    assign br_live = br_req & ~br_done;

    mss_branch_filter #(
        .NUM_STAGES(NUM_STAGES),
        .TID_W     (TID_W),
        .SEQ_W     (SEQ_W),
        .STG_W     (STG_W)
    ) u_filter (
        .req       (br_live),
        .tid_flat  (br_tid),
        .seq_flat  (br_seq),
        .stall_take(st_take),
        .stall_tid (st_tid),
        .stall_thr (st_thr),
        .br_take   (br_take),
        .br_stage  (br_stage),
        .take_tid  (take_tid),
        .take_thr  (take_thr),
        .done      (done_d)
    );

    always_comb begin
        for (int s = 0; s < NUM_STAGES; s++) begin
            mask_d[s] = (st_take  && STG_W'(s) <= st_stage) ||
                        (br_take  && STG_W'(s) <= br_stage);
        end
    end

    // state register: detect / count / fire
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            ev_stage_q <= '0;
            ev_tid_q   <= '0;
            ev_seq_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (pick_found && SQ_DELAY != 0) begin
                        state_q    <= ST_DELAY;
                        cnt_q      <= CNT_W'(SQ_DELAY);
                        ev_stage_q <= pick_stage;
                        ev_tid_q   <= pick_tid;
                        ev_seq_q   <= pick_seq;
                    end
                end
                ST_DELAY: begin
                    if (cnt_q == CNT_W'(1)) begin
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // registered squash outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_squash  <= '0;
            squash_tid    <= '0;
            squash_thresh <= '0;
            mem_squash    <= 1'b0;
            mem_keep_seq  <= '0;
            br_done       <= '0;
        end else begin
            stage_squash  <= mask_d;
            squash_tid    <= (st_take || br_take) ? take_tid : '0;
            squash_thresh <= (st_take || br_take) ? take_thr : '0;
            mem_squash    <= st_take;
            mem_keep_seq  <= st_take ? st_seq : '0;
            br_done       <= done_d;
        end
    end

endmodule

// File: rtl/mss_checker.sv
module mss_checker #(
    parameter int NUM_STAGES = 5,
    parameter int SEQ_W      = 16,
    parameter int TID_W      = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    restore_req,
    input logic [TID_W-1:0]        restore_tid,
    input logic [NUM_STAGES-1:0]   stage_squash,
    input logic [SEQ_W-1:0]        squash_thresh,
    input logic                    mem_squash,
    input logic [SEQ_W-1:0]        mem_keep_seq,
    input logic [NUM_STAGES-1:0]   br_done,
    input logic [(2**TID_W)-1:0]   parked_valid,
    input logic                    reinject_vld,
    input logic [TID_W-1:0]        reinject_tid
);

    assert_squash_contiguous_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_squash != '0) |->
            (stage_squash[0] && (((stage_squash + NUM_STAGES'(1)) & stage_squash) == '0)));

    assert_park_one_per_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(parked_valid) <= $countones($past(parked_valid)) + 1);

    assert_mem_keeps_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_squash |-> (stage_squash[0] && mem_keep_seq == squash_thresh + SEQ_W'(1)));

    assert_reinject_after_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reinject_vld |-> ($past(restore_req) && $past(restore_tid) == reinject_tid));

    assert_ack_with_squash_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (br_done != '0) |-> (stage_squash != '0));

    for (genvar t = 0; t < 2**TID_W; t++) begin : g_hold
        assert_park_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(parked_valid[t]) |-> ($past(restore_req) && $past(restore_tid) == TID_W'(t)));
    end

endmodule

bind miss_switch_squash mss_checker #(
    .NUM_STAGES(NUM_STAGES),
    .SEQ_W     (SEQ_W),
    .TID_W     (TID_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .restore_req  (restore_req),
    .restore_tid  (restore_tid),
    .stage_squash (stage_squash),
    .squash_thresh(squash_thresh),
    .mem_squash   (mem_squash),
    .mem_keep_seq (mem_keep_seq),
    .br_done      (br_done),
    .parked_valid (parked_valid),
    .reinject_vld (reinject_vld),
    .reinject_tid (reinject_tid)
);

// File: tb/test_miss_switch_squash.sv
`timescale 1ns/1ps
module test_miss_switch_squash;

    localparam int NS = 5;
    localparam int SW = 16;
    localparam int TW = 2;
    localparam int IW = 32;
    localparam int NT = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              switch_on_miss;
    logic [NS-1:0]     stall_flag;
    logic [NS*TW-1:0]  stall_tid;
    logic [NS*SW-1:0]  stall_seq;
    logic [NS*IW-1:0]  stall_inst;
    logic [NS-1:0]     br_req;
    logic [NS*TW-1:0]  br_tid;
    logic [NS*SW-1:0]  br_seq;
    logic              restore_req;
    logic [TW-1:0]     restore_tid;

    logic [NS-1:0] stage_squash, d_stage_squash;
    logic [TW-1:0] squash_tid, d_squash_tid;
    logic [SW-1:0] squash_thresh, d_squash_thresh;
    logic          mem_squash, d_mem_squash;
    logic [SW-1:0] mem_keep_seq, d_mem_keep_seq;
    logic [NS-1:0] br_done, d_br_done;
    logic [NT-1:0] parked_valid, d_parked_valid;
    logic          reinject_vld, d_reinject_vld;
    logic [TW-1:0] reinject_tid, d_reinject_tid;
    logic [SW-1:0] reinject_seq, d_reinject_seq;
    logic [IW-1:0] reinject_inst, d_reinject_inst;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    miss_switch_squash i_miss_switch_squash (
        .clk(clk), .rst_n(rst_n), .switch_on_miss(switch_on_miss),
        .stall_flag(stall_flag), .stall_tid(stall_tid), .stall_seq(stall_seq),
        .stall_inst(stall_inst), .br_req(br_req), .br_tid(br_tid), .br_seq(br_seq),
        .restore_req(restore_req), .restore_tid(restore_tid),
        .stage_squash(stage_squash), .squash_tid(squash_tid),
        .squash_thresh(squash_thresh), .mem_squash(mem_squash),
        .mem_keep_seq(mem_keep_seq), .br_done(br_done), .parked_valid(parked_valid),
        .reinject_vld(reinject_vld), .reinject_tid(reinject_tid),
        .reinject_seq(reinject_seq), .reinject_inst(reinject_inst)
    );

    miss_switch_squash #(.SQ_DELAY(3)) i_miss_switch_squash_dly (
        .clk(clk), .rst_n(rst_n), .switch_on_miss(switch_on_miss),
        .stall_flag(stall_flag), .stall_tid(stall_tid), .stall_seq(stall_seq),
        .stall_inst(stall_inst), .br_req(br_req), .br_tid(br_tid), .br_seq(br_seq),
        .restore_req(restore_req), .restore_tid(restore_tid),
        .stage_squash(d_stage_squash), .squash_tid(d_squash_tid),
        .squash_thresh(d_squash_thresh), .mem_squash(d_mem_squash),
        .mem_keep_seq(d_mem_keep_seq), .br_done(d_br_done), .parked_valid(d_parked_valid),
        .reinject_vld(d_reinject_vld), .reinject_tid(d_reinject_tid),
        .reinject_seq(d_reinject_seq), .reinject_inst(d_reinject_inst)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_stall(input int s, input int t, input int q, input logic [IW-1:0] w);
        stall_flag[s]            = 1'b1;
        stall_tid[s*TW +: TW]    = TW'(t);
        stall_seq[s*SW +: SW]    = SW'(q);
        stall_inst[s*IW +: IW]   = w;
    endtask

    task automatic set_br(input int s, input int t, input int q);
        br_req[s]             = 1'b1;
        br_tid[s*TW +: TW]    = TW'(t);
        br_seq[s*SW +: SW]    = SW'(q);
    endtask

    task automatic do_reset();
        rst_n          = 1'b0;
        switch_on_miss = 1'b1;
        stall_flag     = '0;
        stall_tid      = '0;
        stall_seq      = '0;
        stall_inst     = '0;
        br_req         = '0;
        br_tid         = '0;
        br_seq         = '0;
        restore_req    = 1'b0;
        restore_tid    = '0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R13 stage_squash", 64'(stage_squash), 0);
        chk("R13 mem_squash", 64'(mem_squash), 0);
        chk("R13 br_done", 64'(br_done), 0);
        chk("R13 parked_valid", 64'(parked_valid), 0);
        chk("R13 reinject_vld", 64'(reinject_vld), 0);
        chk("R13 squash_thresh", 64'(squash_thresh), 0);
    endtask

    task automatic t_stall_hold_restore();
        do_reset();
        set_stall(2, 1, 100, 32'hCAFE0001);
        tick();
        chk("R1 mask", 64'(stage_squash), 64'b00111);
        chk("R1 tid", 64'(squash_tid), 1);
        chk("R1 thresh", 64'(squash_thresh), 99);
        chk("R4 mem_squash", 64'(mem_squash), 1);
        chk("R4 mem_keep_seq", 64'(mem_keep_seq), 100);
        chk("R3 parked_valid", 64'(parked_valid), 64'b0010);
        stall_flag = '0;
        tick();
        chk("R5 mask clears", 64'(stage_squash), 0);
        chk("R5 mem clears", 64'(mem_squash), 0);
        set_stall(3, 1, 120, 32'h0BAD0BAD);
        tick();
        chk("R7 no squash on parked thread", 64'(stage_squash), 0);
        chk("R7 parked stays", 64'(parked_valid), 64'b0010);
        stall_flag = '0;
        restore_req = 1'b1;
        restore_tid = 2'd1;
        tick();
        restore_req = 1'b0;
        chk("R8 valid cleared", 64'(parked_valid), 0);
        chk("R8 reinject_vld", 64'(reinject_vld), 1);
        chk("R8 reinject_tid", 64'(reinject_tid), 1);
        chk("R8 R7 reinject_seq not overwritten", 64'(reinject_seq), 100);
        chk("R8 R7 reinject_inst not overwritten", 64'(reinject_inst), 64'hCAFE0001);
        tick();
        chk("R5 reinject clears", 64'(reinject_vld), 0);
        restore_req = 1'b1;
        restore_tid = 2'd0;
        tick();
        restore_req = 1'b0;
        chk("R8 empty restore", 64'(reinject_vld), 0);
        set_stall(3, 1, 120, 32'h0BAD0BAD);
        tick();
        stall_flag = '0;
        chk("R1 re-park after restore mask", 64'(stage_squash), 64'b01111);
        chk("R1 re-park after restore thresh", 64'(squash_thresh), 119);
    endtask

    task automatic t_mode_off();
        do_reset();
        switch_on_miss = 1'b0;
        set_stall(2, 0, 9, 32'h1);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R2 no squash in other mode", 64'(stage_squash), 0);
            chk("R2 nothing parked", 64'(parked_valid), 0);
        end
        switch_on_miss = 1'b1;
        tick();
        stall_flag = '0;
        chk("R2 mode on squashes", 64'(stage_squash), 64'b00111);
    endtask

    task automatic t_stage_priority();
        do_reset();
        set_stall(1, 0, 50, 32'hA);
        set_stall(4, 2, 40, 32'hB);
        tick();
        chk("R6 deepest first mask", 64'(stage_squash), 64'b11111);
        chk("R6 deepest first tid", 64'(squash_tid), 2);
        chk("R6 deepest first thresh", 64'(squash_thresh), 39);
        tick();
        chk("R6 second mask", 64'(stage_squash), 64'b00011);
        chk("R6 second thresh", 64'(squash_thresh), 49);
        chk("R6 both parked", 64'(parked_valid), 64'b0101);
        tick();
        chk("R7 held stalls idle", 64'(stage_squash), 0);
        stall_flag = '0;
    endtask

    task automatic t_branch();
        do_reset();
        set_br(3, 0, 200);
        tick();
        br_req = '0;
        chk("R9 mask", 64'(stage_squash), 64'b01111);
        chk("R9 thresh", 64'(squash_thresh), 200);
        chk("R9 no mem squash", 64'(mem_squash), 0);
        chk("R9 done", 64'(br_done), 64'b01000);
        tick();
        chk("R5 done clears", 64'(br_done), 0);
        set_br(1, 0, 10);
        set_br(4, 3, 20);
        tick();
        br_req[4] = 1'b0;
        chk("R11 deepest branch mask", 64'(stage_squash), 64'b11111);
        chk("R11 deepest branch tid", 64'(squash_tid), 3);
        chk("R11 loser not acked", 64'(br_done), 64'b10000);
        tick();
        br_req = '0;
        chk("R11 deferred taken", 64'(stage_squash), 64'b00011);
        chk("R11 deferred thresh", 64'(squash_thresh), 10);
        chk("R11 deferred done", 64'(br_done), 64'b00010);
    endtask

    task automatic t_filter();
        do_reset();
        set_stall(2, 1, 300, 32'hC);
        set_br(1, 1, 305);
        set_br(3, 2, 500);
        tick();
        stall_flag = '0;
        br_req[1] = 1'b0;
        chk("R11 stall wins mask", 64'(stage_squash), 64'b00111);
        chk("R11 stall wins thresh", 64'(squash_thresh), 299);
        chk("R10 younger same-thread acked", 64'(br_done), 64'b00010);
        tick();
        br_req = '0;
        chk("R11 other thread later mask", 64'(stage_squash), 64'b01111);
        chk("R11 other thread later tid", 64'(squash_tid), 2);
        chk("R11 other thread later done", 64'(br_done), 64'b01000);
        chk("R9 branch no mem", 64'(mem_squash), 0);
    endtask

    task automatic t_wrap();
        do_reset();
        set_stall(0, 2, 0, 32'hD);
        tick();
        stall_flag = '0;
        chk("R1 wrap mask", 64'(stage_squash), 64'b00001);
        chk("R1 wrap thresh", 64'(squash_thresh), 64'hFFFF);
        chk("R4 wrap keep", 64'(mem_keep_seq), 0);
    endtask

    task automatic t_delay();
        do_reset();
        set_stall(1, 3, 77, 32'hE);
        tick();
        stall_flag = '0;
        chk("R12 parked at detect", 64'(d_parked_valid), 64'b1000);
        chk("R12 no squash yet", 64'(d_stage_squash), 0);
        tick();
        chk("R12 no squash yet", 64'(d_stage_squash), 0);
        tick();
        chk("R12 no squash yet", 64'(d_stage_squash), 0);
        tick();
        chk("R12 delayed mask", 64'(d_stage_squash), 64'b00011);
        chk("R12 delayed thresh", 64'(d_squash_thresh), 76);
        chk("R12 delayed mem keep", 64'(d_mem_keep_seq), 77);
        tick();
        chk("R12 pulse ends", 64'(d_stage_squash), 0);
    endtask

    initial begin
        t_reset_state();
        t_stall_hold_restore();
        t_mode_off();
        t_stage_priority();
        t_branch();
        t_filter();
        t_wrap();
        t_delay();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule